// File: doc/BRIEF.md
# Mode-Aware Debug Register Bank

This block holds eight 64-bit debug registers that software reaches through a move-to and move-from register port. Each cycle the caller may present a register index together with a write strobe and write data, a read strobe, or both. A mode input tells the block whether the current code runs in a narrow mode (32-bit or compatibility) or in wide 64-bit mode. The mode sets how much of each register a move sees.

In narrow mode a write stores the low 32 data bits and clears the upper half of the register. A narrow read returns the low half with zeros above it. In wide mode moves carry all 64 bits. Registers 6 and 7 are the status and control registers, and their upper halves are reserved. A wide write that sets any of those reserved bits is refused. The register keeps its old value and a general-protection fault flag, meaning error code zero, pulses for one cycle. Registers 0 to 3 hold addresses and take any 64-bit value without a range check.

Read data is registered. A read returns the value the register held before any write in the same cycle, and the read output holds its value until the next read.

Top module: `dbgreg_bank`

## Requirements
- R1: While reset is active, and after it ends, `rdata` is zero and `gp_fault` is low. After reset, registers 0 to 5 read as zero, register 6 reads 64'h0000_0000_FFFF_0FF0 and register 7 reads 64'h0000_0000_0000_0400.
- R2: A write with `mode_wide`=0 stores `wdata[31:0]` in bits 31:0 of the indexed register and clears bits 63:32, whatever `wdata[63:32]` holds.
- R3: A read with `mode_wide`=0 returns bits 31:0 of the indexed register on `rdata[31:0]`, with `rdata[63:32]` zero.
- R4: With `mode_wide`=1, a write to any of registers 0 to 5 stores all 64 bits of `wdata`, including any upper-bit pattern on registers 0 to 3, and a read returns all 64 bits.
- R5: A write with `mode_wide`=1 to index 6 or 7 with any of `wdata[63:32]` set leaves every register unchanged and drives `gp_fault` high for exactly the cycle after the write strobe. One pulse follows each such write.
- R6: A write with `mode_wide`=1 to index 6 or 7 with `wdata[63:32]` zero is stored and raises no fault.
- R7: `rdata` updates at the clock edge that samples `rd_en` high and holds its value in every cycle where `rd_en` was low.
- R8: A read and a write to the same index in the same cycle return the register's value from before that write.
- R9: `gp_fault` is never raised by a narrow-mode write (including one to index 6 or 7 with upper data bits set), by a read, or by an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| idx | input | 3 | Register index, 0 to 7 |
| wdata | input | 64 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| mode_wide | input | 1 | 1 = 64-bit mode, 0 = 32-bit or compatibility mode |
| rdata | output | 64 | Registered read data |
| gp_fault | output | 1 | One-cycle general-protection fault pulse (error code zero) |

## Verification
The bench aims at the reserved-half rule from several directions. It writes to registers 6 and 7 in wide mode with only bit 63 set, with only bit 32 set, and with the upper half clear. A design that committed a refused write, or that checked the wrong half, shows a changed value on read-back or a missing or stray fault. It issues back-to-back faulting and clean writes, so a fault flag that is latched instead of pulsed stays high where a clean write should leave it low. It sends narrow writes with dirty upper data and then reads them back in wide mode, which exposes a design that fails to clear the upper half. It also issues a read and a write to the same index in one cycle, where a design that forwards the new data would return it early.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;

  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } dbg_mode_e;

  // Power-on contents of each register slot
  function automatic logic [63:0] rst_value(input int unsigned slot);
    case (slot)
      6:       rst_value = 64'h0000_0000_FFFF_0FF0;
      7:       rst_value = 64'h0000_0000_0000_0400;
      default: rst_value = 64'h0;
    endcase
  endfunction

endpackage

// File: rtl/dbgreg_wr_filter.sv
module dbgreg_wr_filter
  import dbgreg_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int NUM_REGS  = 8,
  parameter int RSV_FIRST = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  dbg_mode_e                   mode,
  input  logic [$clog2(NUM_REGS)-1:0] idx,
  input  logic [DATA_W-1:0]           wdata,
  output logic                        commit,
  output logic [DATA_W-1:0]           commit_val,
  output logic                        fault_q
);
  localparam int IDX_W  = $clog2(NUM_REGS);
  localparam int HALF_W = DATA_W / 2;

  logic upper_set;
  logic rsv_hit;
  logic fault_nxt;

  always_comb begin
    upper_set  = |wdata[DATA_W-1:HALF_W];
    rsv_hit    = (idx >= IDX_W'(RSV_FIRST));
    fault_nxt  = wr_en && (mode == MODE_WIDE) && rsv_hit && upper_set;
    commit     = wr_en && !fault_nxt;
    commit_val = (mode == MODE_WIDE) ? wdata
                                     : {{HALF_W{1'b0}}, wdata[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= 1'b0;
    else        fault_q <= fault_nxt;
  end

  // R9
  no_fault_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && (mode == MODE_WIDE)) |-> !fault_q);

endmodule

// File: rtl/dbgreg_store.sv
module dbgreg_store
  import dbgreg_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int NUM_REGS  = 8,
  parameter int RSV_FIRST = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            commit,
  input  logic [$clog2(NUM_REGS)-1:0]     idx,
  input  logic [DATA_W-1:0]               commit_val,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0]   mem_q [NUM_REGS];
  logic [NUM_REGS-1:0] wen;

  always_comb begin
    wen = '0;
    if (commit) wen[idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= DATA_W'(rst_value(i));
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wen[i]) mem_q[i] <= commit_val;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) regs[i] = mem_q[i];
  end

  generate
    for (genvar g = RSV_FIRST; g < NUM_REGS; g++) begin : g_rsv
      // R5
      rsv_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_q[g][DATA_W-1:HALF_W] == '0);
    end
  endgenerate

endmodule

// File: rtl/dbgreg_rd_port.sv
module dbgreg_rd_port
  import dbgreg_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_en,
  input  dbg_mode_e                       mode,
  input  logic [$clog2(NUM_REGS)-1:0]     idx,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  output logic [DATA_W-1:0]               rdata_q
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    sel    = regs[idx];
    rd_nxt = (mode == MODE_WIDE) ? sel : {{HALF_W{1'b0}}, sel[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_nxt;
  end

  // R3
  narrow_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && (mode == MODE_NARROW)) |-> rdata_q[DATA_W-1:HALF_W] == '0);

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rdata_q));

endmodule

// File: rtl/dbgreg_bank.sv
module dbgreg_bank
  import dbgreg_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int NUM_REGS  = 8,
  parameter int RSV_FIRST = 6,
  parameter int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              mode_wide,
  output logic [DATA_W-1:0] rdata,
  output logic              gp_fault
);
  localparam int HALF_W = DATA_W / 2;

  logic [1:0]                       rst_sync_q;
  logic                             rst_int_n;
  dbg_mode_e                        mode;
  logic                             commit;
  logic [DATA_W-1:0]                commit_val;
  logic [NUM_REGS-1:0][DATA_W-1:0]  regs;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign mode = mode_wide ? MODE_WIDE : MODE_NARROW;

  dbgreg_wr_filter #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .RSV_FIRST(RSV_FIRST)
  ) wr_filter_i (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .mode(mode), .idx(idx),
    .wdata(wdata), .commit(commit), .commit_val(commit_val),
    .fault_q(gp_fault)
  );

  dbgreg_store #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .RSV_FIRST(RSV_FIRST)
  ) store_i (
    .clk(clk), .rst_n(rst_int_n), .commit(commit), .idx(idx),
    .commit_val(commit_val), .regs(regs)
  );

  dbgreg_rd_port #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
  ) rd_port_i (
    .clk(clk), .rst_n(rst_int_n), .rd_en(rd_en), .mode(mode), .idx(idx),
    .regs(regs), .rdata_q(rdata)
  );

  // R5
  fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    gp_fault |-> regs == $past(regs));

  // R5
  fault_src_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    gp_fault |-> $past(wr_en) && $past(mode_wide));

  // R2
  narrow_wr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(wr_en && !mode_wide) |-> regs[$past(idx)][DATA_W-1:HALF_W] == '0);

endmodule

// File: tb/dbgreg_bank_tb_top.sv
`timescale 1ns/1ps
module dbgreg_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  idx = '0;
  logic [63:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic        mode_wide = 1'b0;
  logic [63:0] rdata;
  logic        gp_fault;

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] mdl [8];
  logic [63:0] exp_rd = '0;
  logic        exp_flt = 1'b0;

  always #2 clk = ~clk;

  dbgreg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .idx(idx), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .mode_wide(mode_wide), .rdata(rdata), .gp_fault(gp_fault)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) mdl[i] = 64'h0;
    mdl[6] = 64'h0000_0000_FFFF_0FF0;
    mdl[7] = 64'h0000_0000_0000_0400;
    exp_rd  = '0;
    exp_flt = 1'b0;
  endtask

  // One clock of stimulus, model update and comparison
  task automatic cyc(input int i, input logic [63:0] d, input logic we,
                     input logic re, input logic m, input string tag);
    @(negedge clk);
    idx = 3'(i); wdata = d; wr_en = we; rd_en = re; mode_wide = m;
    @(posedge clk);
    if (re) exp_rd = m ? mdl[i] : {32'h0, mdl[i][31:0]};
    exp_flt = we && m && (i >= 6) && (d[63:32] != 32'h0);
    if (we && !exp_flt) mdl[i] = m ? d : {32'h0, d[31:0]};
    #1;
    check(tag, "rdata", rdata, exp_rd);
    check(tag, "gp_fault", {63'h0, gp_fault}, {63'h0, exp_flt});
  endtask

  task automatic idle(input string tag);
    cyc(0, 64'h0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1 outputs quiet during reset
    check("R1", "rdata in reset", rdata, 64'h0);
    check("R1", "gp_fault in reset", {63'h0, gp_fault}, 64'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) idle("R1");

    // R1 reset contents, wide reads
    for (int i = 0; i < 8; i++) cyc(i, 64'h0, 1'b0, 1'b1, 1'b1, "R1");

    // R2 narrow writes with dirty upper data, read back wide
    for (int i = 0; i < 8; i++)
      cyc(i, {32'hDEAD_0000 | 32'(i), 32'h1234_5670 + 32'(i)}, 1'b1, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 8; i++) cyc(i, 64'h0, 1'b0, 1'b1, 1'b1, "R2");

    // R4 wide full writes, including out-of-range addresses on 0..3
    cyc(0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 1'b1, "R4");
    cyc(1, 64'h8000_0000_0000_0001, 1'b1, 1'b0, 1'b1, "R4");
    cyc(2, 64'hA5A5_5A5A_0F0F_F0F0, 1'b1, 1'b0, 1'b1, "R4");
    cyc(3, 64'h0001_0000_0000_0000, 1'b1, 1'b0, 1'b1, "R4");
    cyc(4, 64'h1357_9BDF_2468_ACE0, 1'b1, 1'b0, 1'b1, "R4");
    cyc(5, 64'hFEDC_BA98_7654_3210, 1'b1, 1'b0, 1'b1, "R4");
    for (int i = 0; i < 6; i++) cyc(i, 64'h0, 1'b0, 1'b1, 1'b1, "R4");

    // R3 narrow reads of registers with upper bits set
    for (int i = 0; i < 6; i++) cyc(i, 64'h0, 1'b0, 1'b1, 1'b0, "R3");

    // R5 refused writes, then read back unchanged
    cyc(6, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b1, "R5");
    cyc(7, 64'h0000_0001_FFFF_FFFF, 1'b1, 1'b0, 1'b1, "R5");
    cyc(6, 64'h0000_0000_0000_1111, 1'b1, 1'b0, 1'b1, "R6");
    idle("R5");
    cyc(7, 64'h0, 1'b0, 1'b1, 1'b1, "R5");
    cyc(6, 64'h0, 1'b0, 1'b1, 1'b1, "R6");

    // R6 accepted wide writes to the reserved-half registers
    cyc(7, 64'h0000_0000_ABCD_0401, 1'b1, 1'b0, 1'b1, "R6");
    cyc(7, 64'h0, 1'b0, 1'b1, 1'b1, "R6");

    // R9 narrow writes to 6/7 with dirty upper data never fault
    cyc(6, 64'hFFFF_FFFF_0000_2222, 1'b1, 1'b0, 1'b0, "R9");
    cyc(7, 64'h8000_0000_0000_3333, 1'b1, 1'b0, 1'b0, "R9");
    cyc(6, 64'h0, 1'b0, 1'b1, 1'b1, "R9");
    cyc(7, 64'h0, 1'b0, 1'b1, 1'b1, "R9");

    // R8 read and write to one index in the same cycle
    cyc(2, 64'h0BAD_F00D_CAFE_BEEF, 1'b1, 1'b1, 1'b1, "R8");
    cyc(2, 64'h0, 1'b0, 1'b1, 1'b1, "R8");
    cyc(6, 64'h0000_0000_0000_5555, 1'b1, 1'b1, 1'b0, "R8");

    // R7 output holds while idle or while only writing
    repeat (3) idle("R7");
    cyc(3, 64'h7777_7777_7777_7777, 1'b1, 1'b0, 1'b1, "R7");
    idle("R7");

    // Mixed traffic
    for (int k = 0; k < 400; k++) begin
      logic [63:0] d;
      d = {(($urandom % 3) == 0) ? 32'h0 : 32'($urandom), 32'($urandom)};
      cyc(int'($urandom % 8), d, 1'($urandom), 1'($urandom), 1'($urandom), "R4");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule